// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which pending interrupt request the core should service next. Up to six sources feed it: two external pins, two timer overflows, a serial port and an optional third timer overflow. A request is eligible only when its event flag, its own enable bit and a global enable are all set. Each source carries one priority bit that places it at high or low level. Within a level, a fixed order based on source index breaks ties.

When a request is accepted, the controller drives a one-cycle pulse and a 16-bit vector address. On that pulse the core pushes its program counter and jumps to the vector. The controller records which level is now in service. A high-level request may interrupt a low-level routine. Any request at the same or a lower level than the routine in service waits. A return strobe from the core releases the most recently entered level. Timer overflow flags are given a clear pulse when their vector is taken. The serial flag is left for software to clear.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `vec_valid`, `flag_clr` and `svc_level` are all zero.
- R2: A source is eligible only when `src_flag[i]`, `src_en[i]` and `glob_en` are all 1. With any one of them low, that source never produces `vec_valid`.
- R3: Source indices are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. The vector for source i is 16'h0003 + 8*i, so the vectors run 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh.
- R4: Inputs are sampled at a clock edge. An acceptance decided at that edge shows `vec_valid` high for exactly that one following cycle, with `vec_addr` valid at the same time.
- R5: Among eligible requests at the same level, the lowest source index is accepted.
- R6: An eligible high-level request (`src_hi[i]`=1) wins over every eligible low-level request, whatever the indices.
- R7: A high request is accepted when no high routine is in service, even if a low routine is in service. A low request is accepted only when no routine at either level is in service. Blocked requests stay pending.
- R8: A `reti` pulse releases the high level if it is in service, and otherwise releases the low level. With nothing in service, `reti` has no effect. The acceptance decision in a cycle uses the in-service state from before that cycle's `reti`.
- R9: `flag_clr[i]` pulses together with `vec_valid` only when the accepted source is a timer (index 1, 3 or 5). Sources 0, 2 and 4 never receive a clear pulse.
- R10: `svc_level` bit 1 is high while a high routine is in service, and bit 0 is high while a low routine is in service. Each bit is set in the cycle its vector is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Global interrupt enable |
| src_flag | input | NSRC | Pending event flag per source |
| src_en | input | NSRC | Individual enable per source |
| src_hi | input | NSRC | Priority select per source, 1 = high level |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| vec_valid | output | 1 | One-cycle pulse: push PC and jump to vector |
| vec_addr | output | 16 | Vector address of the accepted source |
| flag_clr | output | NSRC | Clear pulse for auto-cleared timer flags |
| svc_level | output | 2 | In-service levels {high, low} |

## Verification
A corrupted in-service state is visible at the ports in two ways. It appears on `svc_level` in the very next cycle. It also changes which later requests are accepted: a stuck high bit silences every source, and a dropped low bit lets a second low request through too early. A wrong tie-break or a wrong vector computation shows on `vec_addr` in the cycle of the pulse itself. The bench therefore compares every output against a behavioural model on every cycle. The stimulus is arranged so that nesting, blocking and release each have a chance to diverge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int unsigned IDX_W     = 3;
    localparam logic [15:0] VEC_BASE  = 16'h0003;
    localparam logic [15:0] VEC_STEP  = 16'h0008;

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_UART = 3'd4,
        SRC_TMR2 = 3'd5
    } src_id_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } svc_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [15:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_BASE + (16'(idx) * VEC_STEP);
    endfunction

    function automatic logic self_clearing(input logic [IDX_W-1:0] idx);
        return (idx == SRC_TMR0) || (idx == SRC_TMR1) || (idx == SRC_TMR2);
    endfunction

endpackage

// File: rtl/ivc_mask.sv
module ivc_mask #(
    parameter int unsigned N = 6
) (
    input  logic         glob_en,
    input  logic [N-1:0] flag,
    input  logic [N-1:0] en,
    input  logic [N-1:0] hi,
    output logic [N-1:0] req_hi,
    output logic [N-1:0] req_lo
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic live;
        assign live      = flag[g] & en[g] & glob_en;
        assign req_hi[g] = live & hi[g];
        assign req_lo[g] = live & ~hi[g];
    end
endmodule

// File: rtl/ivc_pick.sv
module ivc_pick
    import irq_vec_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] req,
    output pick_t        pick
);
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
            end
        end
    end

    // R5: the chosen index is a real request and no lower index was requesting
    always_comb begin
        if (pick.valid) begin
            assert_pick_lowest_R5: assert (req[pick.idx] && ((req & ((N'(1) << pick.idx) - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/ivc_track.sv
module ivc_track
    import irq_vec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take_hi,
    input  logic take_lo,
    input  logic reti,
    output svc_t svc
);
    svc_t svc_d;

    always_comb begin
        svc_d = svc;
        if (reti) begin
            if (svc.hi) svc_d.hi = 1'b0;
            else        svc_d.lo = 1'b0;
        end
        if (take_hi) svc_d.hi = 1'b1;
        if (take_lo) svc_d.lo = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) svc <= '0;
        else     svc <= svc_d;
    end

    assert_hi_held_R7: assert property (@(posedge clk) disable iff (rst)
        (svc.hi && !reti) |=> svc.hi);
    assert_reti_hi_first_R8: assert property (@(posedge clk) disable iff (rst)
        (reti && svc.hi) |=> !svc.hi);
    assert_reti_lo_next_R8: assert property (@(posedge clk) disable iff (rst)
        (reti && !svc.hi && !take_lo) |=> !svc.lo);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter bit HAS_TMR2 = 1'b1,
    localparam int unsigned NSRC = HAS_TMR2 ? 6 : 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            glob_en,
    input  logic [NSRC-1:0] src_flag,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_hi,
    input  logic            reti,
    output logic            vec_valid,
    output logic [15:0]     vec_addr,
    output logic [NSRC-1:0] flag_clr,
    output logic [1:0]      svc_level
);
    logic [NSRC-1:0]  req_hi, req_lo;
    pick_t            pick_hi, pick_lo;
    svc_t             svc;
    logic             take_hi, take_lo, take;
    logic [IDX_W-1:0] sel;

    ivc_mask #(.N(NSRC)) u_mask (
        .glob_en (glob_en),
        .flag    (src_flag),
        .en      (src_en),
        .hi      (src_hi),
        .req_hi  (req_hi),
        .req_lo  (req_lo)
    );

    ivc_pick #(.N(NSRC)) u_pick_hi (.req(req_hi), .pick(pick_hi));
    ivc_pick #(.N(NSRC)) u_pick_lo (.req(req_lo), .pick(pick_lo));

    assign take_hi = pick_hi.valid && !svc.hi;
    assign take_lo = !take_hi && pick_lo.valid && !svc.hi && !svc.lo;
    assign take    = take_hi || take_lo;
    assign sel     = take_hi ? pick_hi.idx : pick_lo.idx;

    ivc_track u_track (
        .clk     (clk),
        .rst     (rst),
        .take_hi (take_hi),
        .take_lo (take_lo),
        .reti    (reti),
        .svc     (svc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
            flag_clr  <= '0;
        end else begin
            vec_valid <= take;
            if (take) vec_addr <= vec_of(sel);
            flag_clr  <= (take && self_clearing(sel)) ? (NSRC'(1) << sel) : '0;
        end
    end

    assign svc_level = {svc.hi, svc.lo};

    assert_vec_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_addr[2:0] == 3'b011 && vec_addr[15:6] == '0));
    assert_clr_needs_vec_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_clr != '0) |-> (vec_valid && $onehot0(flag_clr)));
    assert_level_marked_R10: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (svc_level != 2'b00));
    assert_gated_by_global_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_valid) |-> $past(glob_en));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         glob_en = 1'b0;
    logic [N-1:0] src_flag = '0, src_en = '0, src_hi = '0;
    logic         reti = 1'b0;
    logic         vec_valid;
    logic [15:0]  vec_addr;
    logic [N-1:0] flag_clr;
    logic [1:0]   svc_level;

    irq_vector_ctrl uut (
        .clk(clk), .rst(rst), .glob_en(glob_en), .src_flag(src_flag),
        .src_en(src_en), .src_hi(src_hi), .reti(reti),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .flag_clr(flag_clr),
        .svc_level(svc_level)
    );

    always #5 clk = ~clk;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string tag   = "R1";

    // behavioural reference
    bit          m_valid, m_hi, m_lo;
    int          m_addr, m_clr, win;
    bit          win_hi;

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0; m_addr = 0; m_clr = 0; m_hi = 0; m_lo = 0;
        end else begin
            win = -1; win_hi = 0;
            if (!m_hi)
                for (int i = 0; i < N; i++)
                    if (win < 0 && glob_en && src_flag[i] && src_en[i] && src_hi[i]) begin
                        win = i; win_hi = 1;
                    end
            if (win < 0 && !m_hi && !m_lo)
                for (int i = 0; i < N; i++)
                    if (win < 0 && glob_en && src_flag[i] && src_en[i] && !src_hi[i]) win = i;
            if (reti) begin
                if (m_hi) m_hi = 0; else m_lo = 0;
            end
            if (win >= 0) begin
                if (win_hi) m_hi = 1; else m_lo = 1;
                m_valid = 1;
                m_addr  = 3 + 8 * win;
                m_clr   = (win == 1 || win == 3 || win == 5) ? (1 << win) : 0;
            end else begin
                m_valid = 0;
                m_clr   = 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(tag, "vec_valid", int'(vec_valid), int'(m_valid));
            if (m_valid) chk(tag, "vec_addr", int'(vec_addr), m_addr);
            chk(tag, "flag_clr", int'(flag_clr), m_clr);
            chk(tag, "svc_level", int'(svc_level), int'({m_hi, m_lo}));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ret_once();
        reti = 1'b1; cyc(1); reti = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        tag = "R1";
        cyc(3);
        chk("R1", "reset vec_valid", int'(vec_valid), 0);
        chk("R1", "reset svc_level", int'(svc_level), 0);
        rst = 1'b0;
        cyc(1);
        chk("R1", "post-reset flag_clr", int'(flag_clr), 0);

        // R2 gating
        tag = "R2";
        src_flag = '1; src_en = '0; glob_en = 1'b1; cyc(3);
        src_en = '1; glob_en = 1'b0; cyc(3);
        chk("R2", "no vec while gated", int'(vec_valid), 0);
        src_flag = '0; src_en = 6'b000100; glob_en = 1'b1; src_flag = 6'b000011; cyc(3);
        chk("R2", "disabled sources ignored", int'(svc_level), 0);
        src_flag = '0;

        // R3 / R9 / R4 each source alone at low level
        src_en = '1;
        for (int s = 0; s < N; s++) begin
            tag = "R3";
            src_flag = 6'(1 << s); cyc(1);
            chk("R3", "vector address", int'(vec_addr), 3 + 8 * s);
            chk("R9", "timer auto-clear", int'(flag_clr),
                (s == 1 || s == 3 || s == 5) ? (1 << s) : 0);
            src_flag = '0; cyc(1);
            chk("R4", "single pulse", int'(vec_valid), 0);
            ret_once(); cyc(1);
        end

        // R5 tie-break
        tag = "R5";
        src_flag = 6'b110110; cyc(1);
        chk("R5", "lowest index wins", int'(vec_addr), 16'h000B);
        src_flag = '0; ret_once(); cyc(1);

        // R6 high beats low
        tag = "R6";
        src_hi = 6'b010000; src_flag = 6'b010001; cyc(1);
        chk("R6", "high over low", int'(vec_addr), 16'h0023);
        chk("R10", "high level marked", int'(svc_level), 2);
        src_flag = '0; ret_once(); cyc(1);

        // R7 nesting
        tag = "R7";
        src_hi = 6'b001000; src_flag = 6'b000100; cyc(1);
        chk("R10", "low level marked", int'(svc_level), 1);
        src_flag = 6'b000001; cyc(3);
        chk("R7", "low blocked by low", int'(vec_valid), 0);
        src_flag = 6'b001001; cyc(1);
        chk("R7", "high preempts low", int'(vec_addr), 16'h001B);
        src_flag = 6'b000001; cyc(2);
        tag = "R8";
        ret_once(); cyc(1);
        chk("R8", "high released first", int'(svc_level), 1);
        src_flag = '0;
        ret_once(); cyc(1);
        chk("R8", "low released", int'(svc_level), 0);
        ret_once(); cyc(1);
        chk("R8", "spare reti ignored", int'(svc_level), 0);

        // mixed traffic
        tag = "R7";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom;
            src_flag = ((r & 7) == 0) ? 6'(r >> 3) : '0;
            src_en   = 6'(r >> 9) | 6'b100101;
            src_hi   = 6'(r >> 15);
            glob_en  = ((r >> 21) & 7) != 0;
            reti     = ((r >> 24) & 3) == 0;
            cyc(1);
        end
        reti = 1'b0; src_flag = '0;
        cyc(2);
        finish_run();
    end
endmodule